// File: doc/BRIEF.md
# Nonvolatile Write Commit Gate

This block sits between the serial front end of a small nonvolatile memory and the nonvolatile programming engine. Every write request that the front end decodes at STOP is offered to the gate together with a flag saying whether the frame had the right bit count. The gate decides whether the request may become a nonvolatile cycle. When the request is accepted it issues a one-cycle commit strobe carrying the address and data. When it is refused it issues a one-cycle reject strobe. Requests that only change volatile state, such as the write-enable latch or the unlock key steps, produce neither strobe.

A write is allowed only when every one of these checks passes. The write-enable latch must be set. The hardware protect pin must be low. The supply must be above its trip level. For array writes, the target address must lie outside the block-locked region. For control register writes, a three-key unlock sequence must have completed just before the write.

A committed write starts a busy period of fixed length. During the busy period every request is refused, which is what makes acknowledge polling work. A refused write starts no busy period, so the next poll is answered at once. The control register holds a two-bit block-lock level. The gate keeps that level and applies it to later array writes.

Top module: `wr_commit_gate`

## Requirements
- R1: An array write (request kind 0) commits only when the write-enable latch is set, the protect pin is low and the address is not locked. The commit strobe is high in the cycle after the request, with the request's address and data, and it is high for one cycle only. Otherwise the request is rejected.
- R2: Request kind 2 sets the write-enable latch and kind 3 clears it. Neither kind produces a commit or a reject strobe, and a commit leaves the latch unchanged.
- R3: A request whose frame-valid flag is low is rejected and changes no state. For example, a kind 2 request with a bad frame leaves the latch clear.
- R4: A control write (kind 1) commits only if the three preceding accepted requests were key writes (kind 4) with data 0x3C, 0xA5 and 0x5A, in that order. The latch must also be set and the protect pin low. A commit loads the block-lock level from data bits [1:0]. The unlock_ready output shows that all three keys have been received.
- R5: The unlock sequence returns to its first step on any of these: a key write with the wrong value, any other accepted request, or a control write, whether that control write commits or not.
- R6: While the protect pin is high, both array writes and control writes are rejected.
- R7: The block-lock level selects the protected addresses. Level 0 protects nothing. Level 1 protects addresses whose two top bits are 11. Level 2 protects addresses whose top bit is 1. Level 3 protects every address.
- R8: In any cycle where low_volt is high, a request gives neither strobe. That cycle also clears the write-enable latch, the unlock sequence and any busy period. The block-lock level is kept.
- R9: A commit makes busy high for exactly BUSY_CYC cycles. A request during busy is rejected and changes no state. A rejected write leaves busy low.
- R10: Request kinds 5 to 7 are rejected and change no state.
- R11: After reset, commit, reject, busy, wel, unlock_ready and lock_level are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle pulse: a decoded request is present |
| req_kind | input | 3 | 0 array, 1 control, 2 set latch, 3 clear latch, 4 key |
| req_addr | input | ADDR_W | Array address |
| req_data | input | DATA_W | Write data or key value |
| req_frame_ok | input | 1 | Frame had the correct bit count before STOP |
| wp_pin | input | 1 | Hardware protect pin, high blocks writes |
| low_volt | input | 1 | Supply below trip level |
| commit | output | 1 | Nonvolatile cycle start strobe |
| commit_ctrl | output | 1 | The commit targets the control register |
| commit_addr | output | ADDR_W | Address of the last commit |
| commit_data | output | DATA_W | Data of the last commit |
| reject | output | 1 | Request refused strobe |
| busy | output | 1 | Nonvolatile cycle in progress |
| wel | output | 1 | Write-enable latch state |
| lock_level | output | 2 | Block-lock level in force |
| unlock_ready | output | 1 | All three keys received |

## Verification
The hardest situations to reach are those that show the unlock sequence was reset. Such a reset leaves no mark at the ports until a later key write fails to complete the sequence. The stimulus therefore interrupts a partly entered sequence with one of three things: a wrong key, a latch command, or a control write refused because the protect pin is high. It then replays the remaining keys and checks that unlock_ready stays low. The busy window needs similar care. A request is placed inside the busy window and the exact falling cycle of busy is counted. Low voltage is also raised during a busy period and during a finished unlock, to show that both are cleared while the lock level survives.

// File: rtl/wg_pkg.sv
package wg_pkg;

    typedef enum logic [2:0] {
        WK_ARRAY   = 3'd0,
        WK_CTRL    = 3'd1,
        WK_WEL_SET = 3'd2,
        WK_WEL_CLR = 3'd3,
        WK_KEY     = 3'd4
    } wr_kind_e;

    typedef enum logic [1:0] {
        LK_NONE    = 2'd0,
        LK_QUARTER = 2'd1,
        LK_HALF    = 2'd2,
        LK_ALL     = 2'd3
    } lock_lvl_e;

    localparam logic [2:0] KIND_MAX = 3'd4;

endpackage

// File: rtl/wg_lock_range.sv
module wg_lock_range #(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        lvl,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    import wg_pkg::*;

    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    always_comb begin
        unique case (lock_lvl_e'(lvl))
            LK_NONE:    hit = 1'b0;
            LK_QUARTER: hit = addr[TOP] & addr[NXT];
            LK_HALF:    hit = addr[TOP];
            LK_ALL:     hit = 1'b1;
            default:    hit = 1'b0;
        endcase
    end

    // R7: the whole-array level covers the lowest address
    always_comb begin
        if (lvl == 2'd3 && addr == '0)
            a_all_covers_zero_r7: assert (hit);
    end

endmodule

// File: rtl/wg_unlock_seq.sv
module wg_unlock_seq #(
    parameter int          DATA_W = 8,
    parameter logic [7:0]  KEY0   = 8'h3C,
    parameter logic [7:0]  KEY1   = 8'hA5,
    parameter logic [7:0]  KEY2   = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              ev_valid,
    input  logic              ev_key,
    input  logic [DATA_W-1:0] ev_data,
    output logic              ready
);
    localparam int STEPS = 3;
    localparam int SW    = $clog2(STEPS + 1);
    localparam logic [SW-1:0] LAST = SW'(STEPS);

    logic [SW-1:0] step_d, step_q;
    logic          key_match;

    always_comb begin
        case (step_q)
            SW'(0):  key_match = (ev_data[7:0] == KEY0);
            SW'(1):  key_match = (ev_data[7:0] == KEY1);
            SW'(2):  key_match = (ev_data[7:0] == KEY2);
            default: key_match = 1'b0;
        endcase
    end

    always_comb begin
        step_d = step_q;
        if (clear) begin
            step_d = '0;
        end else if (ev_valid) begin
            if (ev_key && key_match) step_d = step_q + SW'(1);
            else                     step_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= '0;
        else        step_q <= step_d;
    end

    assign ready = (step_q == LAST);

    // R5: the step only advances by one or falls back to the start
    p_step_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q != $past(step_q)) |-> (step_q == '0 || step_q == $past(step_q) + SW'(1)));

    // R8: a low-voltage cycle leaves the sequence at its start
    p_clear_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (step_q == '0));

endmodule

// File: rtl/wg_busy_timer.sv
module wg_busy_timer #(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (abort)              cnt_d = '0;
        else if (start)         cnt_d = LOAD;
        else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R9: an undisturbed busy period counts down one step per cycle
    p_busy_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) != '0 && !$past(abort) && !$past(start))
            |-> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/wr_commit_gate.sv
module wr_commit_gate #(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 8,
    parameter int BUSY_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_frame_ok,
    input  logic              wp_pin,
    input  logic              low_volt,
    output logic              commit,
    output logic              commit_ctrl,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              reject,
    output logic              busy,
    output logic              wel,
    output logic [1:0]        lock_level,
    output logic              unlock_ready
);
    import wg_pkg::*;

    typedef struct packed {
        logic              commit;
        logic              commit_ctrl;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              reject;
        logic              wel;
        logic [1:0]        lock;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic busy_w, ready_w, prot_w;
    logic live, accept, is_arr, is_ctl, is_key, known, go;
    logic arr_ok, ctl_ok;

    wg_lock_range #(.ADDR_W(ADDR_W)) i_range (
        .lvl  (st_q.lock),
        .addr (req_addr),
        .hit  (prot_w)
    );

    wg_unlock_seq #(.DATA_W(DATA_W)) i_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (low_volt),
        .ev_valid (accept),
        .ev_key   (is_key),
        .ev_data  (req_data),
        .ready    (ready_w)
    );

    wg_busy_timer #(.BUSY_CYC(BUSY_CYC)) i_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .abort (low_volt),
        .busy  (busy_w)
    );

    always_comb begin
        known  = (req_kind <= KIND_MAX);
        is_arr = (req_kind == WK_ARRAY);
        is_ctl = (req_kind == WK_CTRL);
        is_key = (req_kind == WK_KEY);
        live   = req_valid && !low_volt;
        accept = live && !busy_w && req_frame_ok && known;
        arr_ok = st_q.wel && !wp_pin && !prot_w;
        ctl_ok = st_q.wel && !wp_pin && ready_w;
        go     = accept && ((is_arr && arr_ok) || (is_ctl && ctl_ok));

        st_d             = st_q;
        st_d.commit      = 1'b0;
        st_d.commit_ctrl = 1'b0;
        st_d.reject      = 1'b0;

        if (live && !go && (!accept || is_arr || is_ctl))
            st_d.reject = 1'b1;

        if (go) begin
            st_d.commit      = 1'b1;
            st_d.commit_ctrl = is_ctl;
            st_d.addr        = req_addr;
            st_d.data        = req_data;
            if (is_ctl) st_d.lock = req_data[1:0];
        end

        if (accept && req_kind == WK_WEL_SET) st_d.wel = 1'b1;
        if (accept && req_kind == WK_WEL_CLR) st_d.wel = 1'b0;
        if (low_volt)                         st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit       = st_q.commit;
    assign commit_ctrl  = st_q.commit_ctrl;
    assign commit_addr  = st_q.addr;
    assign commit_data  = st_q.data;
    assign reject       = st_q.reject;
    assign wel          = st_q.wel;
    assign lock_level   = st_q.lock;
    assign busy         = busy_w;
    assign unlock_ready = ready_w;

    // R1: a commit requires the latch set and the pin low one cycle before
    p_commit_needs_wel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(wel) && !$past(wp_pin)));

    // R4: a control commit follows a completed unlock
    p_ctrl_needs_unlock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ctrl |-> $past(ready_w));

    // R4: the lock level moves only with a control commit
    p_lock_moves_on_ctrl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_level != $past(lock_level)) |-> commit_ctrl);

    // R8: low voltage silences both strobes and drops the latch
    p_lowvolt_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(low_volt) |-> (!commit && !reject && !wel && !busy));

    // R9: a commit never starts inside a busy period
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !$past(busy_w));

    // R9: commit and reject never coincide
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && reject));

endmodule

// File: tb/test_wr_commit_gate.sv
`timescale 1ns/1ps
module test_wr_commit_gate;

    localparam int ADDR_W   = 9;
    localparam int DATA_W   = 8;
    localparam int BUSY_CYC = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              req_frame_ok = 1'b0;
    logic              wp_pin = 1'b0;
    logic              low_volt = 1'b0;
    logic              commit, commit_ctrl, reject, busy, wel, unlock_ready;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;
    logic [1:0]        lock_level;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    wr_commit_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) i_wr_commit_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .req_frame_ok(req_frame_ok),
        .wp_pin(wp_pin), .low_volt(low_volt), .commit(commit), .commit_ctrl(commit_ctrl),
        .commit_addr(commit_addr), .commit_data(commit_data), .reject(reject),
        .busy(busy), .wel(wel), .lock_level(lock_level), .unlock_ready(unlock_ready)
    );

    typedef struct packed {
        logic [2:0] kind;
        logic [8:0] addr;
        logic [7:0] data;
        logic       ok;
        logic       wp;
        logic       lv;
        logic       ec;
        logic       er;
        logic       ewel;
        logic [1:0] elock;
        logic       erdy;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 9'h010, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0}, // R1 no latch
        '{3'd2, 9'h000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0}, // R3 bad frame
        '{3'd2, 9'h000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0}, // R2 set
        '{3'd0, 9'h010, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0}, // R1 commit
        '{3'd0, 9'h011, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0}, // R6
        '{3'd1, 9'h000, 8'h01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0}, // R4 locked
        '{3'd4, 9'h000, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0},
        '{3'd4, 9'h000, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0},
        '{3'd4, 9'h000, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1}, // R4 ready
        '{3'd1, 9'h000, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0}, // R6 R5
        '{3'd4, 9'h000, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0},
        '{3'd4, 9'h000, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0},
        '{3'd4, 9'h000, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1},
        '{3'd1, 9'h000, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R4 commit
        '{3'd0, 9'h1C0, 8'h33, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0}, // R7 quarter
        '{3'd0, 9'h17F, 8'h44, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0}, // R7 outside
        '{3'd4, 9'h000, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd4, 9'h000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R5 wrong key
        '{3'd4, 9'h000, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd4, 9'h000, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd2, 9'h000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0}, // R5 other req
        '{3'd4, 9'h000, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd4, 9'h000, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd4, 9'h000, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0},
        '{3'd4, 9'h000, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1},
        '{3'd1, 9'h000, 8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0}, // R4 half
        '{3'd0, 9'h100, 8'h55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0}, // R7 half
        '{3'd0, 9'h0FF, 8'h66, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0}, // R7 lower
        '{3'd3, 9'h000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0}, // R2 clear
        '{3'd0, 9'h000, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0}, // R1
        '{3'd5, 9'h000, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0}, // R10
        '{3'd0, 9'h000, 8'h88, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0}  // R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives at a falling edge, returns at the falling edge after the capture.
    task automatic send(input logic [2:0] k, input logic [8:0] a, input logic [7:0] d,
                        input logic ok, input logic wp, input logic lv);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_data = d;
        req_frame_ok = ok; wp_pin = wp; low_volt = lv;
        @(negedge clk);
        req_valid = 1'b0; wp_pin = 1'b0; low_volt = 1'b0; req_frame_ok = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * BUSY_CYC && busy; i++) @(negedge clk);
    endtask

    task automatic unlock();
        send(3'd4, '0, 8'h3C, 1'b1, 1'b0, 1'b0);
        send(3'd4, '0, 8'hA5, 1'b1, 1'b0, 1'b0);
        send(3'd4, '0, 8'h5A, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 commit", commit, 0);
        chk("R11 reject", reject, 0);
        chk("R11 busy", busy, 0);
        chk("R11 wel", wel, 0);
        chk("R11 lock", lock_level, 0);
        chk("R11 ready", unlock_ready, 0);

        for (int n = 0; n < NV; n++) begin
            send(VEC[n].kind, VEC[n].addr, VEC[n].data, VEC[n].ok, VEC[n].wp, VEC[n].lv);
            chk($sformatf("R1 R4 row %0d commit", n), commit, VEC[n].ec);
            chk($sformatf("R3 R10 row %0d reject", n), reject, VEC[n].er);
            chk($sformatf("R2 row %0d wel", n), wel, VEC[n].ewel);
            chk($sformatf("R7 row %0d lock", n), lock_level, VEC[n].elock);
            chk($sformatf("R5 row %0d ready", n), unlock_ready, VEC[n].erdy);
            if (VEC[n].ec) begin
                chk($sformatf("R1 row %0d addr", n), commit_addr, VEC[n].addr);
                chk($sformatf("R1 row %0d data", n), commit_data, VEC[n].data);
                chk($sformatf("R4 row %0d ctrl", n), commit_ctrl, VEC[n].kind == 3'd1);
            end
            wait_idle();
        end

        // R9 rejected write leaves busy low
        send(3'd2, '0, 8'h00, 1'b1, 1'b0, 1'b0);
        send(3'd0, 9'h003, 8'h10, 1'b1, 1'b1, 1'b0);
        chk("R9 reject no busy", {reject, busy}, 2'b10);

        // R9 busy length and request during busy
        send(3'd0, 9'h004, 8'h20, 1'b1, 1'b0, 1'b0);
        chk("R9 commit", commit, 1);
        chk("R9 busy start", busy, 1);
        send(3'd3, '0, 8'h00, 1'b1, 1'b0, 1'b0);
        chk("R9 busy request rejected", reject, 1);
        chk("R9 busy request no effect", wel, 1);
        chk("R1 single cycle strobe", commit, 0);
        repeat (BUSY_CYC - 2) @(negedge clk);
        chk("R9 busy last cycle", busy, 1);
        @(negedge clk);
        chk("R9 busy ended", busy, 0);

        // R8 low voltage clears latch, unlock and busy; keeps lock level
        unlock();
        chk("R8 pre ready", unlock_ready, 1);
        low_volt = 1'b1;
        @(negedge clk);
        low_volt = 1'b0;
        chk("R8 wel cleared", wel, 0);
        chk("R8 ready cleared", unlock_ready, 0);
        chk("R8 lock kept", lock_level, 2);
        send(3'd2, '0, 8'h00, 1'b1, 1'b0, 1'b0);
        send(3'd0, 9'h005, 8'h30, 1'b1, 1'b0, 1'b0);
        chk("R8 busy set", busy, 1);
        low_volt = 1'b1;
        @(negedge clk);
        low_volt = 1'b0;
        chk("R8 busy aborted", busy, 0);

        // R7 full lock then no lock
        send(3'd2, '0, 8'h00, 1'b1, 1'b0, 1'b0);
        unlock();
        send(3'd1, '0, 8'h03, 1'b1, 1'b0, 1'b0);
        chk("R4 lock all", lock_level, 3);
        wait_idle();
        send(3'd0, 9'h000, 8'h40, 1'b1, 1'b0, 1'b0);
        chk("R7 all locked", reject, 1);
        unlock();
        send(3'd1, '0, 8'h00, 1'b1, 1'b0, 1'b0);
        chk("R4 lock none", lock_level, 0);
        wait_idle();
        send(3'd0, 9'h1FF, 8'h50, 1'b1, 1'b0, 1'b0);
        chk("R7 none locked", commit, 1);
        chk("R1 top addr", commit_addr, 9'h1FF);
        wait_idle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule